// File: doc/BRIEF.md
# Open-Drain Half-Duplex Line Repeater

This block joins pairs of open-drain data lines, one on the card side and one on the host side, and repeats a low level from whichever side starts a transfer onto the other. Each line is seen as a sampled input level plus two enables the block drives: one that pulls the line low and one that gives it a short active-high boost. A pull-up holds the line high outside the block. Three identical channels (data and two auxiliary lines) are built from one channel module, and all three share the clock, the reset and a chip-select input.

In each channel both inputs pass through a synchroniser, and falling edges are found on the synchronised values. The first side to fall becomes the master. Edge detection on the other side, the slave, stops at once. After a programmable delay of TD clock cycles, the low is copied onto the slave. When the master goes high again, the slave's pull-low is removed and a boost drives the slave high for TD cycles. The channel then returns to idle. Edges are only taken from a high-to-low step on the synchronised level, so a line that is still low from an earlier conflict cannot start a new transfer.

When chip select is low, the host side reads as high and takes no part in arbitration, and the host-side outputs stay off. With the default 125 MHz clock, TD = 12 gives 96 ns, which lies inside the required 50 to 400 ns window. A full low/high cycle then takes well under the 5 µs that a 200 kHz line rate allows.

Top module: `odr_line_repeater`

## Requirements
- R1: While reset is high and on the first cycle after it, all pull-low and boost outputs are 0.
- R2: If the card side falls first on a channel, that channel's host pull-low rises exactly TD+3 clock edges after the card input goes low (two synchroniser stages, one edge-detect edge, TD delay edges). The card pull-low stays 0.
- R3: If the host side falls first, the same rule applies with the sides swapped: the card pull-low rises TD+3 edges after the host input goes low, and the host pull-low stays 0.
- R4: If both sides fall on the same synchronised cycle, the card side becomes master.
- R5: While a master is being served, a fall or rise on the slave's input has no effect on the outputs until the master is released.
- R6: When the master goes high, the slave's pull-low drops and its boost rises on the same edge, 3 edges after the master input rises. The boost lasts exactly TD cycles, and then every output of the channel is 0.
- R7: No line is ever pulled low and boosted at the same time, and a channel never pulls both of its sides low at once.
- R8: One cycle after both synchronised inputs are high, neither pull-low is active. A side that is still low when the channel goes back to idle does not start a new transfer. Only a fresh high-to-low step does.
- R9: While chip select is 0, the host pull-low and host boost stay 0, and a low on the host input starts no transfer.
- R10: If the master goes high again before the TD delay ends, nothing is copied and no boost is given.
- R11: The channels work independently. A transfer on one channel leaves the outputs of the others at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select; 1 lets the host side take part |
| card_line_i | input | N_CH | Sampled card-side line levels |
| host_line_i | input | N_CH | Sampled host-side line levels |
| card_pull_lo_o | output | N_CH | Pull card line low |
| card_boost_o | output | N_CH | Actively drive card line high |
| host_pull_lo_o | output | N_CH | Pull host line low |
| host_boost_o | output | N_CH | Actively drive host line high |

## Verification
If a channel takes the wrong side as master, the pull-low shows up on the side that is driving, at TD+3 edges, and nothing is copied to the other side. Checking the exact edge in both directions catches this at once. A counter that is off by one moves the pull-low or the boost edge by one cycle, so both windows are sampled at their first and last cycle. Anti-latch or edge-detection faults only show later, as a pull-low that appears with no fresh fall on the line. So after every conflict and every chip-select-off test, the outputs are watched for a full window of several TD periods.

// File: rtl/odr_pkg.sv
package odr_pkg;

  // Per-channel sequencing state
  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_CARD_WAIT  = 3'd1,  // card master, delaying copy to host
    ST_CARD_HOLD  = 3'd2,  // card master, host held low
    ST_CARD_BOOST = 3'd3,  // card released, host boosted high
    ST_HOST_WAIT  = 3'd4,
    ST_HOST_HOLD  = 3'd5,
    ST_HOST_BOOST = 3'd6
  } rpt_state_e;

endpackage

// File: rtl/odr_sync.sv
module odr_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '1;
        else     stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '1;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/odr_channel.sv
module odr_channel
  import odr_pkg::*;
#(
  parameter int TD_CYCLES = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_i,
  input  logic card_s_i,
  input  logic host_s_i,
  output logic card_pull_lo_o,
  output logic card_boost_o,
  output logic host_pull_lo_o,
  output logic host_boost_o
);

  localparam int CNT_W = (TD_CYCLES > 1) ? $clog2(TD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TD_CYCLES - 1);

  rpt_state_e       state_q, state_n;
  logic [CNT_W-1:0] cnt_q;
  logic             card_prev_q, host_prev_q;
  logic             host_eff, card_fall, host_fall, cnt_last;

  // Deselected host side reads as released
  assign host_eff  = host_s_i | ~cs_i;
  assign card_fall = card_prev_q & ~card_s_i;
  assign host_fall = host_prev_q & ~host_eff;
  assign cnt_last  = (cnt_q == CNT_LAST);

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (card_fall)      state_n = ST_CARD_WAIT;   // card wins a tie
        else if (host_fall) state_n = ST_HOST_WAIT;
      end
      ST_CARD_WAIT:  if (card_s_i) state_n = ST_IDLE;
                     else if (cnt_last) state_n = ST_CARD_HOLD;
      ST_CARD_HOLD:  if (card_s_i) state_n = ST_CARD_BOOST;
      ST_CARD_BOOST: if (cnt_last) state_n = ST_IDLE;
      ST_HOST_WAIT:  if (host_eff) state_n = ST_IDLE;
                     else if (cnt_last) state_n = ST_HOST_HOLD;
      ST_HOST_HOLD:  if (host_eff) state_n = ST_HOST_BOOST;
      ST_HOST_BOOST: if (cnt_last) state_n = ST_IDLE;
      default:       state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= ST_IDLE;
      cnt_q          <= '0;
      card_prev_q    <= 1'b1;
      host_prev_q    <= 1'b1;
      card_pull_lo_o <= 1'b0;
      card_boost_o   <= 1'b0;
      host_pull_lo_o <= 1'b0;
      host_boost_o   <= 1'b0;
    end else begin
      state_q        <= state_n;
      cnt_q          <= (state_n != state_q) ? '0 : cnt_q + 1'b1;
      card_prev_q    <= card_s_i;
      host_prev_q    <= host_eff;
      card_pull_lo_o <= (state_n == ST_HOST_HOLD);
      card_boost_o   <= (state_n == ST_HOST_BOOST);
      host_pull_lo_o <= (state_n == ST_CARD_HOLD)  & cs_i;
      host_boost_o   <= (state_n == ST_CARD_BOOST) & cs_i;
    end
  end

  // R7: a line is never pulled low and boosted together
  assert_no_fight_R7: assert property (@(posedge clk) disable iff (rst)
    !(card_pull_lo_o && card_boost_o) && !(host_pull_lo_o && host_boost_o));

  // R7: only the slave side is ever pulled
  assert_one_side_R7: assert property (@(posedge clk) disable iff (rst)
    !(card_pull_lo_o && host_pull_lo_o));

  // R8: both sides released means no pull on the next cycle
  assert_anti_latch_R8: assert property (@(posedge clk) disable iff (rst)
    (card_s_i && host_eff) |=> (!card_pull_lo_o && !host_pull_lo_o));

  // R6: a boost only follows removal of that side's pull-low
  assert_boost_after_pull_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(card_boost_o) |-> $past(card_pull_lo_o));

  // R9: deselected host side stays quiet
  assert_cs_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !cs_i |=> (!host_pull_lo_o && !host_boost_o));

  // R4: simultaneous fall resolves to card master
  assert_card_priority_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && card_fall && host_fall) |=> (state_q == ST_CARD_WAIT));

endmodule

// File: rtl/odr_line_repeater.sv
module odr_line_repeater #(
  parameter int N_CH        = 3,
  parameter int TD_CYCLES   = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cs_i,
  input  logic [N_CH-1:0] card_line_i,
  input  logic [N_CH-1:0] host_line_i,
  output logic [N_CH-1:0] card_pull_lo_o,
  output logic [N_CH-1:0] card_boost_o,
  output logic [N_CH-1:0] host_pull_lo_o,
  output logic [N_CH-1:0] host_boost_o
);

  logic [N_CH-1:0] card_s, host_s;

  odr_sync #(.WIDTH(N_CH), .STAGES(SYNC_STAGES)) u_card_sync (
    .clk(clk), .rst(rst), .d_i(card_line_i), .q_o(card_s)
  );

  odr_sync #(.WIDTH(N_CH), .STAGES(SYNC_STAGES)) u_host_sync (
    .clk(clk), .rst(rst), .d_i(host_line_i), .q_o(host_s)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    odr_channel #(.TD_CYCLES(TD_CYCLES)) u_ch (
      .clk            (clk),
      .rst            (rst),
      .cs_i           (cs_i),
      .card_s_i       (card_s[c]),
      .host_s_i       (host_s[c]),
      .card_pull_lo_o (card_pull_lo_o[c]),
      .card_boost_o   (card_boost_o[c]),
      .host_pull_lo_o (host_pull_lo_o[c]),
      .host_boost_o   (host_boost_o[c])
    );
  end

endmodule

// File: tb/odr_line_repeater_tb.sv
module odr_line_repeater_tb;

  localparam int N  = 3;
  localparam int TD = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cs  = 1'b1;
  logic [N-1:0] card_ext = '1, host_ext = '1;
  logic [N-1:0] card_line, host_line;
  logic [N-1:0] card_pull, card_boost, host_pull, host_boost;

  int checks = 0, fails = 0, viol = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  // wired-AND open-drain lines
  assign card_line = card_ext & ~card_pull;
  assign host_line = host_ext & ~host_pull;

  odr_line_repeater #(.N_CH(N), .TD_CYCLES(TD), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .cs_i(cs),
    .card_line_i(card_line), .host_line_i(host_line),
    .card_pull_lo_o(card_pull), .card_boost_o(card_boost),
    .host_pull_lo_o(host_pull), .host_boost_o(host_boost)
  );

  // R7 monitor
  always @(negedge clk)
    if (!rst && (((card_pull & card_boost) | (host_pull & host_boost) | (card_pull & host_pull)) != '0))
      viol++;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_card(input int ch, input logic v);
    @(negedge clk); card_ext[ch] = v;
  endtask

  task automatic set_host(input int ch, input logic v);
    @(negedge clk); host_ext[ch] = v;
  endtask

  task automatic t_reset;
    chk("R1", "outputs in reset", int'({card_pull, card_boost, host_pull, host_boost}), 0);
    @(negedge clk); rst = 1'b0;
    wait_edges(1);
    chk("R1", "outputs after reset", int'({card_pull, card_boost, host_pull, host_boost}), 0);
  endtask

  task automatic t_card_master(input int ch);
    set_card(ch, 1'b0);
    wait_edges(TD + 2);
    chk("R2", "host pull before delay", host_pull[ch], 0);
    wait_edges(1);
    chk("R2", "host pull at TD+3", host_pull[ch], 1);
    chk("R2", "card not pulled", card_pull[ch], 0);
    wait_edges(4);
    set_card(ch, 1'b1);
    wait_edges(2);
    chk("R6", "host still pulled", host_pull[ch], 1);
    wait_edges(1);
    chk("R6", "host pull dropped", host_pull[ch], 0);
    chk("R6", "host boost start", host_boost[ch], 1);
    wait_edges(TD - 1);
    chk("R6", "host boost last cycle", host_boost[ch], 1);
    wait_edges(1);
    chk("R6", "channel idle", int'({card_pull[ch], card_boost[ch], host_pull[ch], host_boost[ch]}), 0);
  endtask

  task automatic t_host_master(input int ch);
    set_host(ch, 1'b0);
    wait_edges(TD + 2);
    chk("R3", "card pull before delay", card_pull[ch], 0);
    wait_edges(1);
    chk("R3", "card pull at TD+3", card_pull[ch], 1);
    chk("R3", "host not pulled", host_pull[ch], 0);
    wait_edges(3);
    set_host(ch, 1'b1);
    wait_edges(3);
    chk("R6", "card boost start", card_boost[ch], 1);
    chk("R6", "card pull dropped", card_pull[ch], 0);
    wait_edges(TD);
    chk("R6", "card boost ended", card_boost[ch], 0);
  endtask

  task automatic t_tie_and_conflict;
    @(negedge clk); card_ext[0] = 1'b0; host_ext[0] = 1'b0;
    wait_edges(TD + 3);
    chk("R4", "tie: host pulled", host_pull[0], 1);
    chk("R4", "tie: card not pulled", card_pull[0], 0);
    set_card(0, 1'b1);                     // host still held low outside
    wait_edges(3);
    chk("R8", "conflict boost on host", host_boost[0], 1);
    wait_edges(TD);
    chk("R8", "released after conflict", int'({card_pull[0], host_pull[0]}), 0);
    wait_edges(2 * TD);
    chk("R8", "stale low starts nothing", int'({card_pull[0], host_pull[0], card_boost[0], host_boost[0]}), 0);
    set_host(0, 1'b1);
    wait_edges(TD + 6);
    chk("R8", "quiet after host release", int'({card_pull[0], host_pull[0]}), 0);
  endtask

  task automatic t_slave_ignored;
    set_card(0, 1'b0);
    wait_edges(4);
    set_host(0, 1'b0);
    wait_edges(TD);
    chk("R5", "host copied despite slave fall", host_pull[0], 1);
    chk("R5", "card not pulled by slave", card_pull[0], 0);
    set_host(0, 1'b1);
    wait_edges(3);
    chk("R5", "slave rise ignored", int'({card_pull[0], host_pull[0], host_boost[0]}), 3'b010);
    set_card(0, 1'b1);
    wait_edges(3);
    chk("R5", "boost after master release", host_boost[0], 1);
    wait_edges(TD);
  endtask

  task automatic t_chip_select;
    @(negedge clk); cs = 1'b0;
    set_host(2, 1'b0);
    wait_edges(TD + 6);
    chk("R9", "deselected host starts nothing", card_pull[2], 0);
    set_host(2, 1'b1);
    set_card(2, 1'b0);
    wait_edges(TD + 3);
    chk("R9", "host pull gated", host_pull[2], 0);
    set_card(2, 1'b1);
    wait_edges(3);
    chk("R9", "host boost gated", host_boost[2], 0);
    wait_edges(TD + 2);
    @(negedge clk); cs = 1'b1;
    wait_edges(2);
    t_host_master(2);
  endtask

  task automatic t_short_pulse;
    bit seen = 1'b0;
    set_card(1, 1'b0);
    wait_edges(4);
    set_card(1, 1'b1);
    for (int i = 0; i < TD + 8; i++) begin
      wait_edges(1);
      if (host_pull[1] || host_boost[1]) seen = 1'b1;
    end
    chk("R10", "short pulse not copied", seen, 0);
  endtask

  task automatic t_independent;
    set_card(1, 1'b0);
    wait_edges(TD + 3);
    chk("R11", "only ch1 host pulled", int'(host_pull), 3'b010);
    chk("R11", "no card pulls", int'(card_pull), 0);
    set_card(1, 1'b1);
    wait_edges(TD + 4);
    chk("R11", "all idle", int'({card_pull, host_pull, card_boost, host_boost}), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    wait_edges(3);
    t_card_master(0);
    t_host_master(0);
    t_tie_and_conflict();
    t_card_master(0);
    t_slave_ignored();
    t_chip_select();
    t_short_pulse();
    t_independent();
    t_card_master(2);
    chk("R7", "pull/boost overlap count", viol, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule